// File: doc/BRIEF.md
# Timekeeping Register Window

This block is the byte-wide access window of a battery-backed timekeeping memory. A synchronous bus reads and writes a large byte-addressed space. The eight highest addresses hold the clock and calendar registers and every other address goes to plain storage. The clock registers that software sees are a separate copy that sits beside the live calendar counters, which are outside this block. The live count arrives on `live_time`, and the block hands user-set values back on a one-cycle load strobe.

Register 0 holds the century and two halt bits. A read-halt bit freezes the visible copy so that software gets one consistent snapshot while the counters keep running. A write-halt bit opens the time fields to software writes. Clearing it commits the loaded values to the counters. The block also holds an oscillator stop bit, a frequency-test bit that makes the seconds LSB follow a square wave, and a read-only battery flag. All bits without a clock function are ordinary storage.

Top module: `rtc_regwin`

## Requirements
- R1: An address whose bits ADDR_W-1..3 are all ones selects clock register (address & 7): 0 century/control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Any other address is plain storage indexed by its low RAM_AW bits, so addresses that agree in those bits alias. Read data appears on `bus_rdata` the cycle after the read request and holds until the next read.
- R2: While register 0 bits 7 and 6 are both 0, each `tick_sec` copies the time fields of `live_time` (byte n at bits 8n+7..8n) into the visible registers. The time-field masks per register are 0x3F, 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F, 0xFF. `load_time` always shows the visible time fields.
- R3: While register 0 bit 6 (read halt) is 1, `tick_sec` leaves the visible registers unchanged. After the bit is cleared, the next tick refreshes them.
- R4: While register 0 bit 7 (write halt) is 1, ticks are ignored and writes store time fields. A write to register 0 that clears the bit raises `load_stb` for exactly one cycle, starting the cycle after the write, with `load_time` carrying the loaded values, including the century from that write.
- R5: While write halt is 0, writes leave time-field bits unchanged.
- R6: When both halt bits are 1, write halt governs: time-field writes are accepted and ticks are ignored.
- R7: Seconds bit 7 is the oscillator stop bit. `osc_en` is its inverse and changes the cycle after the write.
- R8: When day bit 6 is 1 and the oscillator runs, the seconds LSB reads a phase that is 0 when the mode starts and inverts on each `tick_ft`. Otherwise the stored LSB is read.
- R9: Day bit 7 reads `batt_ok` as sampled in the read cycle. Writes to it have no visible effect.
- R10: Bits outside the time-field masks (halt, stop, test and spare bits) are always writable storage.
- R11: After reset all clock registers are 0, `osc_en` is 1, `load_stb` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| tick_sec | input | 1 | One-second pulse from the counters |
| tick_ft | input | 1 | Frequency-test pulse |
| batt_ok | input | 1 | Battery good |
| live_time | input | 64 | Live counter values, byte n = register n |
| osc_en | output | 1 | Oscillator enable to the counters |
| load_stb | output | 1 | Commit pulse for the counters |
| load_time | output | 64 | Visible time fields, byte n = register n |

## Verification
The visible copy is driven with ticks under four halt settings: neither bit set, read halt only, write halt only, and both bits set. These runs tell freezing apart from loading, and they show which bit wins when both are set. Writes are applied with and without write halt and with spare bits toggled, which separates time fields from storage bits. Storage accesses just below the window and at aliased addresses check the decode boundary. The frequency-test readback is sampled across several test pulses with the oscillator running and then stopped, and the battery flag is read with both battery levels and after a write to it.

// File: rtl/rtc_regwin_pkg.sv
package rtc_regwin_pkg;
  localparam int NREG  = 8;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_CTL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SEC = 3'd1;
  localparam logic [OFF_W-1:0] OFF_DAY = 3'd4;

  localparam int BIT_WHALT = 7;  // in register 0
  localparam int BIT_RHALT = 6;  // in register 0
  localparam int BIT_OSC   = 7;  // in seconds
  localparam int BIT_FT    = 6;  // in day
  localparam int BIT_BATT  = 7;  // in day

  // bits of each register that belong to the counters
  function automatic logic [7:0] time_mask(input int idx);
    case (idx)
      0:       return 8'h3F;
      1:       return 8'h7F;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_store.sv
module rtc_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wdata,
  input  logic              tick_sec,
  input  logic [8*NREG-1:0] live_time,
  output logic [8*NREG-1:0] bank,
  output logic              load_stb
);
  logic halt_w, halt_r, refresh;

  assign halt_w  = bank[BIT_WHALT];
  assign halt_r  = bank[BIT_RHALT];
  assign refresh = tick_sec && !halt_w && !halt_r;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] TM = time_mask(g);
    logic       hit;
    logic [7:0] cur, tsrc, ssrc, r;

    assign hit = wr_en && (off == OFF_W'(g));
    assign cur = bank[8*g +: 8];

    always_comb begin
      if (refresh)            tsrc = live_time[8*g +: 8];
      else if (hit && halt_w) tsrc = wdata;
      else                    tsrc = cur;
      ssrc = hit ? wdata : cur;
    end

    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= (tsrc & TM) | (ssrc & ~TM);
    end

    assign bank[8*g +: 8] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) load_stb <= 1'b0;
    else     load_stb <= wr_en && (off == OFF_CTL) && halt_w && !wdata[BIT_WHALT];
  end
endmodule

// File: rtl/rtc_ftgen.sv
module rtc_ftgen (
  input  logic clk,
  input  logic rst,
  input  logic ft_on,
  input  logic osc_run,
  input  logic tick,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (rst || !ft_on || !osc_run) phase <= 1'b0;
    else if (tick)                 phase <= ~phase;
  end
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_regwin_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_sec,
  input  logic              tick_ft,
  input  logic              batt_ok,
  input  logic [63:0]       live_time,
  output logic              osc_en,
  output logic              load_stb,
  output logic [63:0]       load_time
);
  localparam int WIN_HI = ADDR_W - 1;

  logic              in_win, rd_req, wr_req, ft_phase;
  logic [OFF_W-1:0]  off;
  logic [8*NREG-1:0] bank;
  logic [7:0]        ram_q, win_byte, win_q;
  logic              is_win_q;

  assign in_win = &bus_addr[WIN_HI:OFF_W];
  assign off    = bus_addr[OFF_W-1:0];
  assign rd_req = bus_sel && !bus_wr;
  assign wr_req = bus_sel && bus_wr;

  rtc_store #(.AW(RAM_AW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_req && !in_win),
    .re    (rd_req && !in_win),
    .addr  (bus_addr[RAM_AW-1:0]),
    .wdata (bus_wdata),
    .q     (ram_q)
  );

  rtc_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_req && in_win),
    .off       (off),
    .wdata     (bus_wdata),
    .tick_sec  (tick_sec),
    .live_time (live_time),
    .bank      (bank),
    .load_stb  (load_stb)
  );

  assign osc_en = ~bank[8*int'(OFF_SEC) + BIT_OSC];

  rtc_ftgen u_ft (
    .clk     (clk),
    .rst     (rst),
    .ft_on   (bank[8*int'(OFF_DAY) + BIT_FT]),
    .osc_run (osc_en),
    .tick    (tick_ft),
    .phase   (ft_phase)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign load_time[8*g +: 8] = bank[8*g +: 8] & time_mask(g);
  end

  always_comb begin
    win_byte = bank[8*int'(off) +: 8];
    if (off == OFF_DAY) win_byte[BIT_BATT] = batt_ok;
    if (off == OFF_SEC && bank[8*int'(OFF_DAY) + BIT_FT] && osc_en)
      win_byte[0] = ft_phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_win_q <= 1'b0;
      win_q    <= '0;
    end else if (rd_req) begin
      is_win_q <= in_win;
      if (in_win) win_q <= win_byte;
    end
  end

  assign bus_rdata = is_win_q ? win_q : ram_q;
endmodule

// File: rtl/rtc_regwin_chk.sv
module rtc_regwin_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              tick_sec,
  input logic              osc_en,
  input logic              load_stb,
  input logic [63:0]       load_time
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = {{(ADDR_W-3){1'b1}}, 3'd0};
  localparam logic [ADDR_W-1:0] SEC_ADDR = {{(ADDR_W-3){1'b1}}, 3'd1};

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb); // R4
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> $past(bus_sel && bus_wr && bus_addr == CTL_ADDR)); // R4
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && bus_wr && bus_addr == SEC_ADDR) |-> $stable(osc_en)); // R7
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_sel && bus_wr) && !$past(tick_sec)) |-> $stable(load_time)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata)); // R1
endmodule

bind rtc_regwin rtc_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick_sec  (tick_sec),
  .osc_en    (osc_en),
  .load_stb  (load_stb),
  .load_time (load_time)
);

// File: tb/tb_rtc_regwin.sv
`timescale 1ns/1ps
module tb_rtc_regwin;
  localparam int AW  = 19;
  localparam int RAW = 10;
  localparam logic [AW-1:0] WIN = 19'h7FFF8;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tick_sec = 0, tick_ft = 0, batt_ok = 1;
  logic [63:0] live_time = '0;
  logic osc_en, load_stb;
  logic [63:0] load_time;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  rtc_regwin #(.ADDR_W(AW), .RAM_AW(RAW)) dut (.*);

  function automatic logic [7:0] tm(input int i);
    case (i)
      0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
      4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_bank [8];
  logic [7:0] m_mem [int];
  logic [7:0] nb [8];
  logic [7:0] e_rd, vb;
  logic m_phase, m_load, hw, hr, win;
  int off, idx;
  logic [63:0] e_time;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_bank[i] = 8'h00;
      m_phase = 0; m_load = 0; e_rd = 8'h00;
    end else begin
      win = (bus_addr >= WIN);
      off = int'(bus_addr[2:0]);
      idx = int'(bus_addr[RAW-1:0]);
      hw  = m_bank[0][7];
      hr  = m_bank[0][6];
      if (bus_sel && !bus_wr) begin
        if (win) begin
          vb = m_bank[off];
          if (off == 4) vb[7] = batt_ok;
          if (off == 1 && m_bank[4][6] && !m_bank[1][7]) vb[0] = m_phase;
          e_rd = vb;
        end else e_rd = m_mem.exists(idx) ? m_mem[idx] : 8'hxx;
      end
      if (bus_sel && bus_wr && !win) m_mem[idx] = bus_wdata;
      m_load = bus_sel && bus_wr && win && off == 0 && hw && !bus_wdata[7];
      if (!m_bank[4][6] || m_bank[1][7]) m_phase = 0;
      else if (tick_ft) m_phase = ~m_phase;
      for (int i = 0; i < 8; i++) begin
        nb[i] = m_bank[i];
        if (tick_sec && !hw && !hr)
          nb[i] = (m_bank[i] & ~tm(i)) | (live_time[8*i +: 8] & tm(i));
        if (bus_sel && bus_wr && win && off == i)
          nb[i] = (bus_wdata & ~tm(i)) | ((hw ? bus_wdata : nb[i]) & tm(i));
      end
      for (int i = 0; i < 8; i++) m_bank[i] = nb[i];
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) e_time[8*i +: 8] = m_bank[i] & tm(i);
    chk("R1 rdata", {56'd0, bus_rdata}, {56'd0, e_rd});
    chk("R7 osc_en", {63'd0, osc_en}, {63'd0, ~m_bank[1][7]});
    chk("R4 load_stb", {63'd0, load_stb}, {63'd0, m_load});
    chk("R2 load_time", load_time, e_time);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rdb(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic pulse_sec();
    @(negedge clk); tick_sec = 1;
    @(negedge clk); tick_sec = 0;
  endtask

  task automatic pulse_ft();
    @(negedge clk); tick_ft = 1;
    @(negedge clk); tick_ft = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 rdata", {56'd0, bus_rdata}, 64'd0);
    chk("R11 osc_en", {63'd0, osc_en}, 64'd1);
    chk("R11 load_time", load_time, 64'd0);
    rst = 0;

    // R1 plain storage, boundary and aliasing
    wr(19'h00123, 8'hA5);
    wr(19'h7FFF7, 8'h3C);
    rdb(19'h00123, rd); chk("R1 ram", {56'd0, rd}, 64'hA5);
    rdb(19'h7FFF7, rd); chk("R1 below window", {56'd0, rd}, 64'h3C);
    rdb(19'h00523, rd); chk("R1 alias", {56'd0, rd}, 64'hA5);

    // R2 refresh on tick
    live_time = 64'h99_12_31_05_23_59_C5_20;
    pulse_sec();
    rdb(WIN + 1, rd); chk("R2 seconds", {56'd0, rd}, 64'h45);
    rdb(WIN + 0, rd); chk("R2 century", {56'd0, rd}, 64'h20);

    // R5 / R10 writes without write halt
    wr(WIN + 1, 8'h12);
    rdb(WIN + 1, rd); chk("R5 time ignored", {56'd0, rd}, 64'h45);
    wr(WIN + 2, 8'h91);
    rdb(WIN + 2, rd); chk("R10 spare bit", {56'd0, rd}, 64'hD9);

    // R3 read halt
    wr(WIN + 0, 8'h40);
    live_time[15:8] = 8'h46;
    pulse_sec();
    rdb(WIN + 1, rd); chk("R3 frozen", {56'd0, rd}, 64'h45);
    wr(WIN + 0, 8'h00);
    pulse_sec();
    rdb(WIN + 1, rd); chk("R3 resumed", {56'd0, rd}, 64'h46);

    // R4 write halt and commit
    wr(WIN + 0, 8'h80);
    wr(WIN + 1, 8'h30);
    wr(WIN + 3, 8'h07);
    live_time[15:8] = 8'h47;
    pulse_sec();
    rdb(WIN + 1, rd); chk("R4 tick ignored", {56'd0, rd}, 64'h30);
    wr(WIN + 0, 8'h19);
    chk("R4 strobe", {63'd0, load_stb}, 64'd1);
    chk("R4 century", {56'd0, load_time[7:0]}, 64'h19);
    chk("R4 seconds", {56'd0, load_time[15:8]}, 64'h30);
    chk("R4 hours", {56'd0, load_time[31:24]}, 64'h07);
    @(negedge clk);
    chk("R4 one cycle", {63'd0, load_stb}, 64'd0);

    // R6 both halt bits
    wr(WIN + 0, 8'hC0);
    wr(WIN + 2, 8'h33);
    pulse_sec();
    rdb(WIN + 2, rd); chk("R6 write wins", {56'd0, rd}, 64'h33);
    wr(WIN + 0, 8'h00);

    // R7 oscillator stop
    wr(WIN + 1, 8'h80);
    chk("R7 stopped", {63'd0, osc_en}, 64'd0);
    rdb(WIN + 1, rd); chk("R7 readback", {56'd0, rd}, 64'hB0);
    wr(WIN + 1, 8'h00);
    chk("R7 running", {63'd0, osc_en}, 64'd1);

    // R8 frequency test
    wr(WIN + 4, 8'h40);
    pulse_ft();
    rdb(WIN + 1, rd); chk("R8 phase 1", {56'd0, rd}, 64'h31);
    pulse_ft();
    rdb(WIN + 1, rd); chk("R8 phase 0", {56'd0, rd}, 64'h30);
    pulse_ft();
    wr(WIN + 1, 8'h80);
    pulse_ft();
    rdb(WIN + 1, rd); chk("R8 stopped osc", {56'd0, rd}, 64'hB0);
    wr(WIN + 1, 8'h00);

    // R9 battery flag
    rdb(WIN + 4, rd); chk("R9 good", {56'd0, rd}, 64'hC5);
    batt_ok = 0;
    rdb(WIN + 4, rd); chk("R9 low", {56'd0, rd}, 64'h45);
    wr(WIN + 4, 8'h80);
    rdb(WIN + 4, rd); chk("R9 write no effect", {56'd0, rd}, 64'h05);
    batt_ok = 1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule